// File: doc/BRIEF.md
# Capture Timer Channel with Deferred Overflow Status

This block is one up-counting timer channel. While running, the counter advances by one on each cycle where the count-enable tick is high. A capture trigger copies the counter value into a capture register. A 3-bit mode input chooses how the channel behaves around a capture. In free capture mode the counter restarts from zero after each capture and keeps running. In single-shot capture mode the counter stops after the first capture until it is started again. Any other mode value gives a plain counter that ignores the capture trigger.

The channel also reports whether the counter wrapped between two captures. A wrap from all-ones to zero does not touch the reported flag directly. The wrap is remembered internally, and the next capture writes the flag: to 1 if a wrap was seen, or to 0 if none was seen. The flag is presented as bit 0 of a read-only 16-bit status word. Outside the two capture modes the flag is frozen.

Top module: `cap_tmr_channel`

## Requirements
- R1: Mode 3'b010 is free capture, in which a capture reloads the counter with zero and the counter keeps running. Mode 3'b110 is single-shot capture, in which a capture stops the counter and holds its value.
- R2: A capture occurs only in modes 3'b010 and 3'b110, only while the counter runs, and only when `start` is low. A capture loads `cap_val` with the counter value held in that cycle.
- R3: A counter wrap from all-ones to zero leaves `status` unchanged in the cycles that follow, up to the next capture.
- R4: At a capture, `status[0]` becomes 1 if a wrap occurred since the previous capture or start, and becomes 0 otherwise.
- R5: A wrap in the same cycle as a capture counts toward that capture, so `status[0]` becomes 1.
- R6: In any mode other than 3'b010 and 3'b110, `status[0]` is neither set nor cleared. Wraps that occur in those modes are not remembered.
- R7: `status` carries the overflow flag in bit 0, and bits 15 to 1 always read 0.
- R8: A synchronous `srst` clears `status`, `count`, `cap_val` and `running` to zero.
- R9: `start` loads the counter with zero, sets `running` and discards any remembered wrap. When `start` and `cap_trig` are high in the same cycle, `start` wins and no capture occurs.
- R10: While `running` is high, the counter increases by one on each `tick` cycle. Without a tick it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Operation mode select |
| tick | input | 1 | Count enable |
| start | input | 1 | Restart the counter from zero and run |
| cap_trig | input | 1 | Capture trigger |
| count | output | CNT_W | Current counter value |
| cap_val | output | CNT_W | Last captured counter value |
| running | output | 1 | Counter is running |
| status | output | 16 | Status word; bit 0 is the overflow flag |

## Verification
The bench runs the counter through real wraps and reads `status` both before and after the following capture. A design that updated the flag at the wrap itself would show it one capture too early. The bench places a wrap and a capture in the same cycle, where a design that sampled only the remembered wrap would report 0. It also lets the counter wrap and fires captures in a non-capture mode, then captures in free mode. A design that remembered those wraps, or let the flag move outside the capture modes, would report the wrong flag. Start colliding with capture, and single-shot stopping, are checked through `count`, `cap_val` and `running`.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
  localparam int          ST_W      = 16;
  localparam int          MODE_W    = 3;
  localparam logic [2:0]  MODE_FREE = 3'b010;
  localparam logic [2:0]  MODE_ONCE = 3'b110;

  function automatic logic [ST_W-1:0] pack_status(input logic ovf);
    logic [ST_W-1:0] w;
    w    = '0;
    w[0] = ovf;
    return w;
  endfunction
endpackage

// File: rtl/cap_tmr_mode_dec.sv
module cap_tmr_mode_dec
  import cap_tmr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              cap_mode,
  output logic              once_mode
);
  logic is_free;
  assign is_free   = (mode == MODE_FREE);
  assign once_mode = (mode == MODE_ONCE);
  assign cap_mode  = is_free | once_mode;
endmodule

// File: rtl/cap_tmr_counter.sv
module cap_tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             start,
  input  logic             cap_trig,
  input  logic             cap_mode,
  input  logic             once_mode,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             run_q,
  output logic             cap_ev,
  output logic             wrap_ev
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_ONE;
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return v == CNT_TOP;
  endfunction

  assign cap_ev  = cap_trig & cap_mode & run_q & ~start;
  assign wrap_ev = run_q & tick & ~start & at_top(count_q);

  always_ff @(posedge clk) begin
    if (srst) begin
      count_q <= '0;
      cap_q   <= '0;
      run_q   <= 1'b0;
    end else if (start) begin
      count_q <= '0;
      run_q   <= 1'b1;
    end else if (cap_ev) begin
      cap_q <= count_q;
      if (once_mode) run_q   <= 1'b0;
      else           count_q <= '0;
    end else if (run_q && tick) begin
      count_q <= bump(count_q);
    end
  end

  p_once_stop_r1: assert property (@(posedge clk) disable iff (srst)
    (cap_ev && once_mode) |=> (!run_q && $stable(count_q)));
  p_free_restart_r1: assert property (@(posedge clk) disable iff (srst)
    (cap_ev && !once_mode) |=> (count_q == '0 && run_q));
  p_cap_load_r2: assert property (@(posedge clk) disable iff (srst)
    cap_ev |=> (cap_q == $past(count_q)));
  p_start_r9: assert property (@(posedge clk) disable iff (srst)
    start |=> (count_q == '0 && run_q && $stable(cap_q)));
  p_tick_inc_r10: assert property (@(posedge clk) disable iff (srst)
    (run_q && tick && !start && !cap_ev) |=> (count_q == $past(count_q) + CNT_ONE));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (srst)
    (!tick && !start && !cap_ev) |=> $stable(count_q));
endmodule

// File: rtl/cap_tmr_ovf_track.sv
module cap_tmr_ovf_track (
  input  logic clk,
  input  logic srst,
  input  logic start,
  input  logic cap_mode,
  input  logic cap_ev,
  input  logic wrap_ev,
  output logic ovf_flag
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      pend_q   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (cap_ev) ovf_flag <= pend_q | wrap_ev;
      if (start || cap_ev)         pend_q <= 1'b0;
      else if (wrap_ev && cap_mode) pend_q <= 1'b1;
    end
  end

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (srst)
    !cap_ev |=> $stable(ovf_flag));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (srst)
    (cap_ev && !pend_q && !wrap_ev) |=> !ovf_flag);
  p_overflow_set_r4: assert property (@(posedge clk) disable iff (srst)
    (cap_ev && pend_q) |=> ovf_flag);
  p_same_cycle_r5: assert property (@(posedge clk) disable iff (srst)
    (cap_ev && wrap_ev) |=> ovf_flag);
  p_other_mode_r6: assert property (@(posedge clk) disable iff (srst)
    !cap_mode |=> $stable(ovf_flag));
endmodule

// File: rtl/cap_tmr_channel.sv
module cap_tmr_channel
  import cap_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [2:0]       mode,
  input  logic             tick,
  input  logic             start,
  input  logic             cap_trig,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic             running,
  output logic [15:0]      status
);
  logic cap_mode, once_mode, cap_ev, wrap_ev, ovf_flag;

  cap_tmr_mode_dec u_dec (
    .mode      (mode),
    .cap_mode  (cap_mode),
    .once_mode (once_mode)
  );

  cap_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .srst      (srst),
    .tick      (tick),
    .start     (start),
    .cap_trig  (cap_trig),
    .cap_mode  (cap_mode),
    .once_mode (once_mode),
    .count_q   (count),
    .cap_q     (cap_val),
    .run_q     (running),
    .cap_ev    (cap_ev),
    .wrap_ev   (wrap_ev)
  );

  cap_tmr_ovf_track u_ovf (
    .clk      (clk),
    .srst     (srst),
    .start    (start),
    .cap_mode (cap_mode),
    .cap_ev   (cap_ev),
    .wrap_ev  (wrap_ev),
    .ovf_flag (ovf_flag)
  );

  assign status = pack_status(ovf_flag);

  p_status_hi_r7: assert property (@(posedge clk) disable iff (srst)
    status[15:1] == '0);
  p_reset_r8: assert property (@(posedge clk)
    srst |=> (status == '0 && count == '0 && cap_val == '0 && !running));
  p_cap_gate_r2: assert property (@(posedge clk) disable iff (srst)
    (!cap_mode || start) |=> $stable(cap_val));
endmodule

// File: tb/cap_tmr_channel_tb.sv
module cap_tmr_channel_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, srst = 1'b1, tick = 1'b0, start = 1'b0, cap_trig = 1'b0;
  logic [2:0]   mode = 3'd0;
  logic [W-1:0] count, cap_val;
  logic         running;
  logic [15:0]  status;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cap_tmr_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .srst(srst), .mode(mode), .tick(tick), .start(start),
    .cap_trig(cap_trig), .count(count), .cap_val(cap_val),
    .running(running), .status(status)
  );

  typedef struct packed {
    logic [2:0]   md;
    logic         tk;
    logic         st;
    logic         cp;
    logic [W-1:0] ecnt;
    logic [W-1:0] ecap;
    logic         eflg;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{3'd2, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 1'b0},
    '{3'd2, 1'b1, 1'b0, 1'b0, 8'd1, 8'd0, 1'b0},
    '{3'd2, 1'b1, 1'b0, 1'b0, 8'd2, 8'd0, 1'b0},
    '{3'd2, 1'b1, 1'b0, 1'b1, 8'd0, 8'd2, 1'b0},
    '{3'd2, 1'b1, 1'b0, 1'b0, 8'd1, 8'd2, 1'b0},
    '{3'd2, 1'b0, 1'b0, 1'b0, 8'd1, 8'd2, 1'b0},
    '{3'd2, 1'b1, 1'b0, 1'b0, 8'd2, 8'd2, 1'b0},
    '{3'd2, 1'b0, 1'b0, 1'b1, 8'd0, 8'd2, 1'b0},
    '{3'd6, 1'b0, 1'b1, 1'b0, 8'd0, 8'd2, 1'b0},
    '{3'd6, 1'b1, 1'b0, 1'b0, 8'd1, 8'd2, 1'b0},
    '{3'd6, 1'b1, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0},
    '{3'd6, 1'b1, 1'b0, 1'b0, 8'd1, 8'd1, 1'b0},
    '{3'd6, 1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0},
    '{3'd0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd1, 1'b0},
    '{3'd0, 1'b1, 1'b0, 1'b0, 8'd1, 8'd1, 1'b0},
    '{3'd0, 1'b1, 1'b0, 1'b1, 8'd2, 8'd1, 1'b0}
  };

  task automatic step(input logic [2:0] m, input logic t, input logic s, input logic c);
    mode = m; tick = t; start = s; cap_trig = c;
    @(posedge clk); #1;
    tick = 1'b0; start = 1'b0; cap_trig = 1'b0;
  endtask

  task automatic ticks(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) step(m, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic chk(input string req, input logic [W-1:0] ecnt,
                     input logic [W-1:0] ecap, input logic eflg);
    total++;
    if (count !== ecnt || cap_val !== ecap || status !== {15'd0, eflg}) begin
      bad++;
      $display("FAIL %s: count=%0d cap=%0d status=%h, expected count=%0d cap=%0d status=%h",
               req, count, cap_val, status, ecnt, ecap, {15'd0, eflg});
    end
  endtask

  task automatic chk_run(input string req, input logic erun);
    total++;
    if (running !== erun) begin
      bad++;
      $display("FAIL %s: running=%0b expected %0b", req, running, erun);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 srst = 1'b0;
    chk("R8 reset state", 8'd0, 8'd0, 1'b0);
    chk_run("R8 reset running", 1'b0);

    // R1 R2 R9 R10 vector walk
    for (int i = 0; i < 16; i++) begin
      step(VEC[i].md, VEC[i].tk, VEC[i].st, VEC[i].cp);
      chk($sformatf("R1/R2/R10 vector %0d", i), VEC[i].ecnt, VEC[i].ecap, VEC[i].eflg);
    end

    // R3 wrap is deferred, R4 set then clear
    step(3'd2, 1'b0, 1'b1, 1'b0);
    ticks(3'd2, 255);
    chk("R10 count to top", 8'd255, 8'd1, 1'b0);
    ticks(3'd2, 1);
    chk("R3 wrap leaves flag", 8'd0, 8'd1, 1'b0);
    ticks(3'd2, 2);
    chk("R3 still deferred", 8'd2, 8'd1, 1'b0);
    step(3'd2, 1'b0, 1'b0, 1'b1);
    chk("R4 capture sets flag", 8'd0, 8'd2, 1'b1);
    ticks(3'd2, 3);
    step(3'd2, 1'b0, 1'b0, 1'b1);
    chk("R4 capture clears flag", 8'd0, 8'd3, 1'b0);

    // R5 wrap and capture in the same cycle
    step(3'd2, 1'b0, 1'b1, 1'b0);
    ticks(3'd2, 255);
    step(3'd2, 1'b1, 1'b0, 1'b1);
    chk("R5 same-cycle wrap", 8'd0, 8'd255, 1'b1);

    // R9 start beats capture
    ticks(3'd2, 4);
    step(3'd2, 1'b0, 1'b1, 1'b1);
    chk("R9 start over capture", 8'd0, 8'd255, 1'b1);
    chk_run("R9 running after start", 1'b1);

    // R6 flag held outside capture modes
    step(3'd0, 1'b0, 1'b1, 1'b0);
    ticks(3'd0, 256);
    step(3'd0, 1'b0, 1'b0, 1'b1);
    chk("R6 flag held at 1", 8'd0, 8'd255, 1'b1);
    step(3'd2, 1'b0, 1'b1, 1'b0);
    step(3'd2, 1'b0, 1'b0, 1'b1);
    chk("R4 no wrap clears", 8'd0, 8'd0, 1'b0);
    step(3'd0, 1'b0, 1'b1, 1'b0);
    ticks(3'd0, 261);
    step(3'd0, 1'b0, 1'b0, 1'b1);
    chk("R6 flag held at 0", 8'd5, 8'd0, 1'b0);
    step(3'd2, 1'b0, 1'b0, 1'b1);
    chk("R6 wraps in other mode forgotten", 8'd0, 8'd5, 1'b0);

    // R1 single-shot with a wrap
    step(3'd6, 1'b0, 1'b1, 1'b0);
    ticks(3'd6, 256);
    step(3'd6, 1'b0, 1'b0, 1'b1);
    chk("R1 single-shot wrap capture", 8'd0, 8'd0, 1'b1);
    chk_run("R1 single-shot stopped", 1'b0);
    ticks(3'd6, 5);
    chk("R1 stopped counter holds", 8'd0, 8'd0, 1'b1);

    // R8 synchronous reset mid-run
    step(3'd2, 1'b0, 1'b1, 1'b0);
    ticks(3'd2, 7);
    srst = 1'b1;
    @(posedge clk); #1;
    srst = 1'b0;
    chk("R8 sync reset clears", 8'd0, 8'd0, 1'b0);
    chk_run("R8 sync reset stops", 1'b0);
    chk("R7 status upper bits", 8'd0, 8'd0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule